// File: doc/BRIEF.md
# Video Memory Address Arbiter

This block decides which of two masters addresses a shared video display memory. The first master is the display controller, which supplies a refresh address. The second is the host processor, which supplies its own address and a request line. The block sends one of the two addresses to the memory. It also tells the host whether it holds the memory through a select flag, or whether its request is being held off through a wait flag.

A 2-bit mode input selects one of three contention policies at run time, so the same datapath can serve different system timing schemes:

- **Host priority.** A host request takes the memory at once.
- **Phase interleave.** The two halves of the host bus cycle are divided between the masters, so neither ever waits.
- **Blanking-only.** The host is admitted only while the vertical retrace flag is high. The screen is never disturbed.

All outputs are registered on the memory clock, so the address source changes on a clean clock edge.

Top module: `vmem_addr_arbiter`

## Requirements
- R1: While rst_ni is low, mem_addr_o is 0 and both host_sel_o and host_wait_o are 0.
- R2: With mode_i = 2'b00 (host priority), host_sel_o takes the value of host_req_i and host_wait_o is 0. mem_addr_o carries host_addr_i when the host is selected, and crtc_addr_i otherwise.
- R3: mode_i = 2'b11 is reserved and behaves exactly like mode 2'b00.
- R4: With mode_i = 2'b01 (interleave), host_sel_o follows host_phase_i: phase 0 gives the refresh address and phase 1 gives the host address. host_req_i has no effect in this mode.
- R5: In interleave mode, host_wait_o is never asserted.
- R6: With mode_i = 2'b10 (blanking-only), a host request made while vretrace_i is 1 is granted: host_sel_o is 1 and mem_addr_o is host_addr_i.
- R7: In blanking-only mode, a host request made while vretrace_i is 0 is refused: host_wait_o is 1, host_sel_o is 0 and mem_addr_o is crtc_addr_i. Without a request, host_wait_o is 0.
- R8: In blanking-only mode, a request held across the rise of vretrace_i is granted in the first registered cycle after the rise, and host_wait_o drops in that same cycle.
- R9: Outputs change only at a rising clk_i edge and reflect the inputs sampled at that edge, giving one cycle of latency.
- R10: host_sel_o and host_wait_o are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Policy: 00 host priority, 01 interleave, 10 blanking-only, 11 reserved (acts as 00) |
| crtc_addr_i | input | 14 | Refresh address from the display controller |
| host_addr_i | input | 14 | Host address |
| host_req_i | input | 1 | Host access request |
| host_phase_i | input | 1 | Host bus phase; high marks the second half of the cycle |
| vretrace_i | input | 1 | Vertical retrace flag |
| mem_addr_o | output | 14 | Registered address to the video memory |
| host_sel_o | output | 1 | Registered flag: the host address is driving the memory |
| host_wait_o | output | 1 | Registered flag: the host request is held off |

## Verification
The hardest situation to reach is a host request that is refused and must then be granted at the exact edge where retrace begins. To reach it, the stimulus holds a request in blanking-only mode with retrace low over several cycles, confirming the wait flag. It then raises retrace while the request stays asserted, and samples the cycle after the rise for grant and wait release. Every combination of mode, request, phase and retrace is also swept with a distinct address pair, so a wrong source selection shows up as a wrong address.

// File: rtl/vmem_arb_pkg.sv
package vmem_arb_pkg;
  typedef enum logic [1:0] {
    ARB_HOSTPRI = 2'b00,
    ARB_INTLV   = 2'b01,
    ARB_VBLANK  = 2'b10,
    ARB_RSVD    = 2'b11
  } arb_mode_e;
endpackage

// File: rtl/vmem_arb_policy.sv
module vmem_arb_policy
  import vmem_arb_pkg::*;
(
  input  arb_mode_e mode_i,
  input  logic      host_req_i,
  input  logic      host_phase_i,
  input  logic      vretrace_i,
  output logic      take_host_o,
  output logic      host_wait_o
);
  always_comb begin
    take_host_o = 1'b0;
    host_wait_o = 1'b0;
    unique case (mode_i)
      ARB_INTLV: take_host_o = host_phase_i;
      ARB_VBLANK: begin
        take_host_o = host_req_i & vretrace_i;
        host_wait_o = host_req_i & ~vretrace_i;
      end
      default: take_host_o = host_req_i; // host priority and reserved
    endcase
  end
endmodule

// File: rtl/vmem_arb_mux_reg.sv
module vmem_arb_mux_reg #(
  parameter int ADDR_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_host_i,
  input  logic              host_wait_i,
  input  logic [ADDR_W-1:0] crtc_addr_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              host_sel_o,
  output logic              host_wait_o
);
  logic [ADDR_W-1:0] addr_d;

  assign addr_d = take_host_i ? host_addr_i : crtc_addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o  <= '0;
      host_sel_o  <= 1'b0;
      host_wait_o <= 1'b0;
    end else begin
      mem_addr_o  <= addr_d;
      host_sel_o  <= take_host_i;
      host_wait_o <= host_wait_i;
    end
  end

  AST_SEL_WAIT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_sel_o && host_wait_o)); // R10
endmodule

// File: rtl/vmem_addr_arbiter.sv
module vmem_addr_arbiter
  import vmem_arb_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] crtc_addr_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_req_i,
  input  logic              host_phase_i,
  input  logic              vretrace_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              host_sel_o,
  output logic              host_wait_o
);
  logic take_host;
  logic wait_req;

  vmem_arb_policy u_policy (
    .mode_i      (arb_mode_e'(mode_i)),
    .host_req_i  (host_req_i),
    .host_phase_i(host_phase_i),
    .vretrace_i  (vretrace_i),
    .take_host_o (take_host),
    .host_wait_o (wait_req)
  );

  vmem_arb_mux_reg #(.ADDR_W(ADDR_W)) u_mux_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_host_i(take_host),
    .host_wait_i(wait_req),
    .crtc_addr_i(crtc_addr_i),
    .host_addr_i(host_addr_i),
    .mem_addr_o (mem_addr_o),
    .host_sel_o (host_sel_o),
    .host_wait_o(host_wait_o)
  );

  // one cycle after reset release, so $past never reaches into reset
  logic chk_armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_armed <= 1'b0;
    else         chk_armed <= 1'b1;
  end

  AST_HOSTPRI_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == 2'b00 || mode_i == 2'b11) && host_req_i) |=> host_sel_o && !host_wait_o); // R2
  AST_INTLV_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01) |=> (host_sel_o == $past(host_phase_i))); // R4
  AST_INTLV_NO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01) |=> !host_wait_o); // R5
  AST_VBL_REFUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && host_req_i && !vretrace_i) |=> host_wait_o && !host_sel_o); // R7
  AST_VBL_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && host_req_i && vretrace_i) |=> host_sel_o); // R6
  AST_HOST_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_armed && host_sel_o) |-> mem_addr_o == $past(host_addr_i)); // R9
  AST_CRTC_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_armed && !host_sel_o) |-> mem_addr_o == $past(crtc_addr_i)); // R9
endmodule

// File: tb/vmem_addr_arbiter_bench.sv
`timescale 1ns/1ps
module vmem_addr_arbiter_bench;
  localparam int AW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [AW-1:0] crtc_a = '0;
  logic [AW-1:0] host_a = '0;
  logic          req = 1'b0, ph = 1'b0, vr = 1'b0;
  logic [AW-1:0] mem_a;
  logic          sel, wt;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  vmem_addr_arbiter #(.ADDR_W(AW)) u_vmem_addr_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .crtc_addr_i(crtc_a), .host_addr_i(host_a),
    .host_req_i(req), .host_phase_i(ph), .vretrace_i(vr),
    .mem_addr_o(mem_a), .host_sel_o(sel), .host_wait_o(wt)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic [1:0] m, input logic v);
    case (m)
      2'b00: return "R2";
      2'b11: return "R3";
      2'b01: return "R4";
      default: return v ? "R6" : "R7";
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    crtc_a = 14'h1A5; host_a = 14'h2C3; req = 1'b1; ph = 1'b1; vr = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 addr", mem_a, 0);
    check("R1 sel", sel, 0);
    check("R1 wait", wt, 0);
    rst_n = 1'b1;

    // exhaustive sweep of mode x req x phase x retrace
    for (int i = 0; i < 32; i++) begin
      logic [1:0] m;
      logic       e_sel, e_wt;
      int         e_addr;
      string      t;
      m = i[4:3];
      @(negedge clk);
      mode = m; req = i[2]; ph = i[1]; vr = i[0];
      crtc_a = AW'((i * 37 + 5));
      host_a = AW'((i * 91 + 1234));
      case (m)
        2'b01:   begin e_sel = ph; e_wt = 1'b0; end
        2'b10:   begin e_sel = req & vr; e_wt = req & ~vr; end
        default: begin e_sel = req; e_wt = 1'b0; end
      endcase
      e_addr = e_sel ? int'(host_a) : int'(crtc_a);
      t = mode_tag(m, vr);
      @(negedge clk);
      check({t, " sel"}, sel, e_sel);
      check({t, " addr"}, mem_a, e_addr);
      check((m == 2'b01) ? "R5 wait" : {t, " wait"}, wt, e_wt);
      check("R10 excl", sel & wt, 0);
    end

    // R8: request held across retrace rise
    @(negedge clk);
    mode = 2'b10; req = 1'b1; vr = 1'b0; ph = 1'b0;
    crtc_a = 14'h0111; host_a = 14'h3EEE;
    repeat (3) begin
      @(negedge clk);
      check("R8 wait before rise", wt, 1);
      check("R8 sel before rise", sel, 0);
    end
    vr = 1'b1;
    #1;
    check("R9 no change before edge", sel, 0);
    @(negedge clk);
    check("R8 grant after rise", sel, 1);
    check("R8 wait release", wt, 0);
    check("R8 addr", mem_a, 14'h3EEE);

    // R9: outputs hold until edge
    @(negedge clk);
    mode = 2'b00; req = 1'b0; crtc_a = 14'h0777;
    #1;
    check("R9 hold addr", mem_a, 14'h3EEE);
    @(negedge clk);
    check("R9 update addr", mem_a, 14'h0777);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule